// File: doc/BRIEF.md
# Pulse-Density Modulated DAC Channel

This block is one output channel of a low-cost digital-to-analog path. A first-order delta-sigma modulator turns a 10-bit code into a one-bit stream. The density of ones in that stream tracks the code, and an external RC filter averages the stream to an analog level of VREF × code / 1024. The modulator spreads its ones as evenly as it can rather than grouping them as a PWM waveform would, so the filtered ripple stays small for a given clock rate.

The code comes from the upper ten bits of a 16-bit value word. A polarity input flips the sense of the channel, so that code 3FFh produces no ones at all. A global soft-disable input parks the output at the polarity level and freezes the modulator. A clock-enable input (the tick) sets the modulator rate. A quad output is four copies of this block that share the soft-disable and tick inputs.

Top module: `pdm_dac_channel`

## Requirements
- R1: The code is bits 15:6 of `value_word`; bits 5:0 have no effect on the output stream.
- R2: With `invert_sense` = 0 and a constant code, every window of 1024 consecutive ticks carries exactly `code` ones (000h gives none, 3FFh gives 1023).
- R3: With `invert_sense` = 1 the effective code is 1023 − code: every 1024-tick window carries exactly 1023 − code ones, so 3FFh gives none and 000h gives 1023.
- R4: The ones are spread evenly. With an effective code of 200h or less, two consecutive ticks never both give a one. With 200h or more, two consecutive ticks never both give a zero.
- R5: While `soft_off` is high, `pdm_out` equals `invert_sense` from the first clock edge that samples `soft_off` high, whatever `tick` does.
- R6: A clock edge with `tick` low, or with `soft_off` high, leaves the modulator state unchanged. Once enabled again, the stream continues from the held state. With `soft_off` low and `tick` low, `pdm_out` does not change.
- R7: Reset (`rst_n` low, asynchronous) drives `pdm_out` to 0 and clears the modulator state.
- R8: `pdm_out` is registered and changes on the clock edge that samples `tick` high. From reset with a constant effective code c, tick n (counting from 1) gives floor(n·c/1024) − floor((n−1)·c/1024).
- R9: A new code takes effect on the next tick and does not clear the modulator state. From reset, three ticks of 700 followed by one tick of 980 give the bits 0, 1, 1, 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| value_word | input | 16 | Value word; the code sits in bits 15:6 |
| invert_sense | input | 1 | 1 inverts the density and sets the disabled level |
| soft_off | input | 1 | Global soft-disable; holds the output at `invert_sense` |
| tick | input | 1 | Modulator clock enable, one step per high cycle |
| pdm_out | output | 1 | One-bit pulse-density stream |

## Verification
The bench counts ones over full 1024-tick windows for codes at zero, full scale, mid scale, a single LSB, and irregular values in both senses. These windows separate correct field extraction and polarity from off-by-one density errors. Bit-exact sequences from reset, taken against a floor-division formula, expose wrong carry timing. A code change partway through a run, a soft-disable period and idle gaps between ticks show whether the modulator state is kept or lost. Runs of adjacent ones and zeros at and around mid scale check that the ones are spread evenly and not grouped as in PWM.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int DEF_CODE_W = 10;
  localparam int DEF_WORD_W = 16;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_MOD   = 2'd1,
    SRC_LEVEL = 2'd2
  } out_src_e;
endpackage

// File: rtl/pdm_code_sel.sv
module pdm_code_sel #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 10
) (
  input  logic [WORD_W-1:0] value_word,
  input  logic              invert_sense,
  output logic [CODE_W-1:0] code_eff
);
  localparam int LSB_POS = WORD_W - CODE_W;

  function automatic logic [CODE_W-1:0] take_field(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:LSB_POS];
  endfunction

  function automatic logic [CODE_W-1:0] apply_sense(input logic [CODE_W-1:0] c,
                                                    input logic inv);
    logic [CODE_W-1:0] full;
    full = '1;
    return inv ? (full - c) : c;
  endfunction

  logic [CODE_W-1:0] raw_code;
  assign raw_code = take_field(value_word);
  assign code_eff = apply_sense(raw_code, invert_sense);

  // R3: full-scale code with inverted sense must yield zero density
  always_comb begin
    if (invert_sense && (&raw_code))
      a_full_inverted_r3: assert (code_eff == '0);
  end
endmodule

// File: rtl/pdm_accum.sv
module pdm_accum #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [CODE_W-1:0] code_eff,
  output logic              carry_now
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [CODE_W-1:0] HALF = CODE_W'(1) << (CODE_W - 1);

  function automatic logic [SUM_W-1:0] add_step(input logic [CODE_W-1:0] a,
                                                input logic [CODE_W-1:0] c);
    return {1'b0, a} + {1'b0, c};
  endfunction

  logic [CODE_W-1:0] acc_q;
  logic              last_carry_q;
  logic [SUM_W-1:0]  sum_w;

  assign sum_w     = add_step(acc_q, code_eff);
  assign carry_now = sum_w[CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q        <= '0;
      last_carry_q <= 1'b0;
    end else if (step_en) begin
      acc_q        <= sum_w[CODE_W-1:0];
      last_carry_q <= sum_w[CODE_W];
    end
  end

  // R6: a cycle without a step leaves the accumulator untouched
  p_acc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en) |=> $stable(acc_q));

  // R4: at or below half scale a one is never followed by a one
  p_sparse_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (code_eff <= HALF) && last_carry_q) |-> !carry_now);
endmodule

// File: rtl/pdm_out_stage.sv
module pdm_out_stage
  import pdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_off,
  input  logic level,
  input  logic step_en,
  input  logic mod_bit,
  output logic pdm_q
);
  out_src_e src;

  always_comb begin
    if (soft_off)     src = SRC_LEVEL;
    else if (step_en) src = SRC_MOD;
    else              src = SRC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdm_q <= 1'b0;
    end else begin
      case (src)
        SRC_LEVEL: pdm_q <= level;
        SRC_MOD:   pdm_q <= mod_bit;
        default:   pdm_q <= pdm_q;
      endcase
    end
  end

  // R5: disabled output follows the polarity level one edge later
  p_parked_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off |=> (pdm_q == $past(level)));

  // R6: idle cycles keep the output bit
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_off && !step_en) |=> $stable(pdm_q));
endmodule

// File: rtl/pdm_dac_channel.sv
module pdm_dac_channel
  import pdm_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] value_word,
  input  logic              invert_sense,
  input  logic              soft_off,
  input  logic              tick,
  output logic              pdm_out
);
  logic [CODE_W-1:0] code_eff;
  logic              step_en;
  logic              mod_bit;

  assign step_en = tick & ~soft_off;

  pdm_code_sel #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_sel (
    .value_word   (value_word),
    .invert_sense (invert_sense),
    .code_eff     (code_eff)
  );

  pdm_accum #(.CODE_W(CODE_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .code_eff  (code_eff),
    .carry_now (mod_bit)
  );

  pdm_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_off (soft_off),
    .level    (invert_sense),
    .step_en  (step_en),
    .mod_bit  (mod_bit),
    .pdm_q    (pdm_out)
  );

  // R7: reset leaves the output low
  p_reset_low_r7: assert property (@(posedge clk)
    (!rst_n) |-> (pdm_out == 1'b0));
endmodule

// File: tb/tb_pdm_dac_channel.sv
`timescale 1ns/1ps
module tb_pdm_dac_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] value_word = '0;
  logic        invert_sense = 1'b0;
  logic        soft_off = 1'b0;
  logic        tick = 1'b0;
  logic        pdm_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pdm_dac_channel dut (
    .clk(clk), .rst_n(rst_n), .value_word(value_word),
    .invert_sense(invert_sense), .soft_off(soft_off),
    .tick(tick), .pdm_out(pdm_out)
  );

  // {word[27:12], invert[11], gap[10], expected ones[9:0]}
  localparam logic [27:0] VEC [8] = '{
    {16'hFFC0, 1'b0, 1'b0, 10'd1023},
    {16'h0000, 1'b0, 1'b0, 10'd0},
    {16'h803F, 1'b0, 1'b1, 10'd512},
    {16'h5540, 1'b0, 1'b0, 10'd341},
    {16'hFFC0, 1'b1, 1'b0, 10'd0},
    {16'h0000, 1'b1, 1'b1, 10'd1023},
    {16'h0040, 1'b0, 1'b0, 10'd1},
    {16'h4D7F, 1'b1, 1'b1, 10'd714}
  };

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int gap, output logic b);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    b = pdm_out;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic b;
    // R7: reset state, even with full-scale code and ticking
    value_word = 16'hFFC0; tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 output low in reset", int'(pdm_out), 0);
    rst_n = 1'b1; tick = 1'b0;
    @(negedge clk);
    check("R7 output low after release", int'(pdm_out), 0);

    // R2 R3 R1: window counts from the vector table
    for (int i = 0; i < 8; i++) begin
      int ones;
      value_word   = VEC[i][27:12];
      invert_sense = VEC[i][11];
      ones = 0;
      for (int n = 0; n < 1024; n++) begin
        step(int'(VEC[i][10]), b);
        ones += int'(b);
      end
      check(VEC[i][11] ? "R3 inverted window count" : "R2 R1 window count",
            ones, int'(VEC[i][9:0]));
    end

    // R8 R1: exact sequence from reset, junk in low bits
    do_reset();
    value_word = 16'h557F; invert_sense = 1'b0;   // code 341
    for (int n = 1; n <= 24; n++) begin
      int e;
      step(0, b);
      e = (n * 341) / 1024 - ((n - 1) * 341) / 1024;
      check($sformatf("R8 R1 tick %0d", n), int'(b), e);
    end

    // R8 R3: exact sequence with inverted sense (effective 1023-100=923)
    do_reset();
    value_word = 16'd100 << 6; invert_sense = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      int e;
      step(0, b);
      e = (n * 923) / 1024 - ((n - 1) * 923) / 1024;
      check($sformatf("R8 R3 tick %0d", n), int'(b), e);
    end

    // R9: code change keeps accumulator
    do_reset();
    invert_sense = 1'b0; value_word = 16'd700 << 6;
    step(0, b); check("R9 bit1", int'(b), 0);
    step(0, b); check("R9 bit2", int'(b), 1);
    step(0, b); check("R9 bit3", int'(b), 1);
    value_word = 16'd980 << 6;
    step(0, b); check("R9 bit after change", int'(b), 1);

    // R4: spacing at and around mid scale
    for (int k = 0; k < 3; k++) begin
      int cd;
      int adj;
      logic prev;
      cd = (k == 0) ? 512 : (k == 1) ? 400 : 600;
      do_reset();
      value_word = 16'(cd << 6); invert_sense = 1'b0;
      adj = 0;
      step(0, prev);
      for (int n = 0; n < 1100; n++) begin
        step(0, b);
        if (cd <= 512 && prev && b) adj++;
        if (cd >= 512 && !prev && !b) adj++;
        prev = b;
      end
      check($sformatf("R4 adjacent runs code %0d", cd), adj, 0);
    end

    // R5: soft-disable parks output at polarity level
    for (int p = 0; p < 2; p++) begin
      int wrong;
      do_reset();
      value_word = 16'h8000; invert_sense = p[0];
      @(negedge clk);
      soft_off = 1'b1; tick = 1'b1;
      wrong = 0;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        if (pdm_out !== p[0]) wrong++;
      end
      tick = 1'b0; soft_off = 1'b0;
      check($sformatf("R5 parked cycles wrong, level %0d", p), wrong, 0);
    end

    // R6: soft-disable freezes accumulator (900 held, 300 more gives a one)
    do_reset();
    invert_sense = 1'b0; value_word = 16'd300 << 6;
    for (int n = 0; n < 3; n++) step(0, b);
    soft_off = 1'b1;
    for (int n = 0; n < 8; n++) step(0, b);
    soft_off = 1'b0;
    step(0, b);
    check("R6 resume after soft-disable", int'(b), 1);

    // R6: idle cycles hold output and state (acc 176 after that step)
    begin
      int moved;
      logic held;
      held = pdm_out;
      moved = 0;
      value_word = 16'd900 << 6;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (pdm_out !== held) moved++;
      end
      check("R6 idle output changes", moved, 0);
      value_word = 16'd300 << 6;
      step(0, b);   // 176+300 = 476, no carry
      check("R6 state kept over idle", int'(b), 0);
      step(0, b);   // 776
      step(0, b);   // 1076 -> carry
      check("R6 carry after idle", int'(b), 1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule